// File: doc/BRIEF.md
# PHY Management Register File

This block holds the control and status registers that a management bridge exposes for a gigabit copper PHY. The bridge presents a register address with a write strobe and write data, or with a read strobe. The block always returns the addressed register's current value on a combinational read bus. A read strobe commits the read at the next clock edge, and that edge is when all read side effects happen.

The link, negotiation and cable logic feed live status levels and one-cycle event pulses into the block. The block turns them into register fields:

- sticky fields that hold an event until software reads it;
- saturating error counters that clear on read;
- a configuration-fault flag fed by a count of failed role resolutions.

Two control bits clear themselves after a write of 1. Each one drives a single-cycle pulse toward the PHY: one for software reset and one for restart of negotiation.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After hardware reset the register reads are as follows. Control (address 0) reads 0x1140: negotiation enable is bit 12, full duplex is bit 8, speed MSB is bit 6. Status (address 1) reads 0x0149 while the negotiation-complete input is low. Role control (address 9) reads 0x0E00. Role status (address 10) reads 0x0000. The receive error counter (address 21) reads 0x0000.
- R2: Writing 1 to control bit 9 (restart) or bit 15 (software reset) makes that bit read 1 for exactly one cycle. During that cycle the matching pulse output is high. The bit then reads 0.
- R3: A software reset returns control to 0x1140 and clears role-control bits 15:13 (test mode). It leaves role-control bits 12:8 (manual enable, manual value, port preference, full and half duplex advertisement) unchanged.
- R4: Status bit 2 (link) is latch-low. Once the link input drops, the bit reads 0 until status is read, even if the link has returned. A read reloads the bit from the live link input.
- R5: Status bit 4 (remote fault) and bit 1 (jabber) are latch-high. A one-cycle event makes the bit read 1 until status is read. The bit reads 0 after that read if no new event arrives.
- R6: A latched event or counter increment that falls in the same cycle as the read of its register is not lost. It is visible on the next read.
- R7: The receive error counter (address 21, 16 bits) counts error pulses. It stops at 0xFFFF instead of wrapping, and it clears when read.
- R8: The idle error count (address 10 bits 7:0) counts idle error pulses. It stops at 0xFF, and it clears when address 10 is read.
- R9: The configuration fault (address 10 bit 15) sets on the seventh failed role resolution since the count was last cleared. It also sets one cycle after a role conflict pulse.
- R10: The configuration fault clears on a read of address 10, on a negotiation-complete pulse, and when the negotiation-enable bit goes from 0 to 1. A negotiation-complete pulse also restarts the failure count from zero.
- R11: Status bits 8, 6, 3 and 0 always read 1. Status bit 5 follows the negotiation-complete input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 5 | Register address for read and write |
| wrEn | input | 1 | Write strobe |
| wrData | input | 16 | Write data |
| rdEn | input | 1 | Read strobe; read side effects occur at this edge |
| rdData | output | 16 | Value of the addressed register |
| linkUp | input | 1 | Live link level |
| remoteFaultIn | input | 1 | Remote fault event |
| jabberIn | input | 1 | Jabber event |
| anCompleteIn | input | 1 | Negotiation complete |
| rxErrPulse | input | 1 | One receive error per cycle high |
| idleErrPulse | input | 1 | One idle error per cycle high |
| msFailPulse | input | 1 | One failed role resolution |
| msRoleConflict | input | 1 | Both ends forced to the same role |
| swResetPulse | output | 1 | Software reset pulse |
| restartAnPulse | output | 1 | Negotiation restart pulse |

## Verification
A read strobe and a new event can land in the same cycle: a jabber pulse, a link drop or a receive error. In that case the clear from the read and the capture of the event compete for the same flop. The bench raises the event input in the very cycle that its read strobe is high. It first confirms that this read still returns the pre-event value. It then expects the following read to show the event, or a count of one.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int REG_AW = 5;
  localparam int DATA_W = 16;

  localparam logic [REG_AW-1:0] ADDR_CTRL   = 5'd0;
  localparam logic [REG_AW-1:0] ADDR_STATUS = 5'd1;
  localparam logic [REG_AW-1:0] ADDR_MSCTL  = 5'd9;
  localparam logic [REG_AW-1:0] ADDR_MSSTAT = 5'd10;
  localparam logic [REG_AW-1:0] ADDR_RXERR  = 5'd21;

  typedef struct packed {
    logic rdStatus;
    logic rdMsStat;
    logic rdRxErr;
    logic anEnRise;
  } strobes_t;
endpackage

// File: rtl/sat_clr_counter.sv
module sat_clr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cnt <= '0;
    else if (clr)
      cnt <= W'(inc);
    else if (inc && cnt != MAXV)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] ctrlWord,
  output logic [DATA_W-1:0] msCtlWord,
  output strobes_t          strb,
  output logic              swResetPulse,
  output logic              restartAnPulse
);
  logic swRstBit, restartBit, loopback, speedLsb, anEnable, powerDown;
  logic isolate, duplex, colTest, speedMsb, anEnPrev;
  logic [2:0] testMode;
  logic msManual, msValue, portType, advFd, advHd;
  logic wrCtrl, wrMs;
  logic unusedWrBits;

  assign wrCtrl = wrEn && (regAddr == ADDR_CTRL);
  assign wrMs   = wrEn && (regAddr == ADDR_MSCTL);
  assign unusedWrBits = ^{wrData[5:0], wrData[7:6]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swRstBit <= 1'b0; restartBit <= 1'b0; loopback <= 1'b0; speedLsb <= 1'b0;
      anEnable <= 1'b1; powerDown <= 1'b0; isolate <= 1'b0; duplex <= 1'b1;
      colTest <= 1'b0; speedMsb <= 1'b1; anEnPrev <= 1'b1;
      testMode <= 3'b000; msManual <= 1'b0; msValue <= 1'b1; portType <= 1'b1;
      advFd <= 1'b1; advHd <= 1'b0;
    end else begin
      anEnPrev <= anEnable;
      if (swRstBit) begin
        swRstBit <= 1'b0; restartBit <= 1'b0; loopback <= 1'b0; speedLsb <= 1'b0;
        anEnable <= 1'b1; powerDown <= 1'b0; isolate <= 1'b0; duplex <= 1'b1;
        colTest <= 1'b0; speedMsb <= 1'b1; testMode <= 3'b000;
      end else begin
        restartBit <= 1'b0;
        if (wrCtrl) begin
          swRstBit   <= wrData[15];
          loopback   <= wrData[14];
          speedLsb   <= wrData[13];
          anEnable   <= wrData[12];
          powerDown  <= wrData[11];
          isolate    <= wrData[10];
          restartBit <= wrData[9];
          duplex     <= wrData[8];
          colTest    <= wrData[7];
          speedMsb   <= wrData[6];
        end
        if (wrMs) begin
          testMode <= wrData[15:13];
          msManual <= wrData[12];
          msValue  <= wrData[11];
          portType <= wrData[10];
          advFd    <= wrData[9];
          advHd    <= wrData[8];
        end
      end
    end
  end

  assign ctrlWord  = {swRstBit, loopback, speedLsb, anEnable, powerDown, isolate,
                      restartBit, duplex, colTest, speedMsb, 6'b0};
  assign msCtlWord = {testMode, msManual, msValue, portType, advFd, advHd, 8'b0};

  assign strb.rdStatus = rdEn && (regAddr == ADDR_STATUS);
  assign strb.rdMsStat = rdEn && (regAddr == ADDR_MSSTAT);
  assign strb.rdRxErr  = rdEn && (regAddr == ADDR_RXERR);
  assign strb.anEnRise = anEnable && !anEnPrev;

  assign swResetPulse   = swRstBit;
  assign restartAnPulse = restartBit;
endmodule

// File: rtl/phy_mgmt_stat.sv
module phy_mgmt_stat
  import phy_mgmt_pkg::*;
#(
  parameter int RXERR_W    = 16,
  parameter int IDLE_W     = 8,
  parameter int FAIL_LIMIT = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  logic               linkUp,
  input  logic               remoteFaultIn,
  input  logic               jabberIn,
  input  logic               anCompleteIn,
  input  logic               rxErrPulse,
  input  logic               idleErrPulse,
  input  logic               msFailPulse,
  input  logic               msRoleConflict,
  output logic               linkLatch,
  output logic               rfLatch,
  output logic               jabLatch,
  output logic               cfgFault,
  output logic [RXERR_W-1:0] rxErrCnt,
  output logic [IDLE_W-1:0]  idleErrCnt
);
  localparam int CNT_W = $clog2(FAIL_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(FAIL_LIMIT);
  localparam logic [CNT_W-1:0] LAST_V  = CNT_W'(FAIL_LIMIT - 1);

  logic [CNT_W-1:0] failCnt;
  logic faultSet, faultClr, cntClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linkLatch <= 1'b0;
      rfLatch   <= 1'b0;
      jabLatch  <= 1'b0;
    end else if (strb.rdStatus) begin
      linkLatch <= linkUp;
      rfLatch   <= remoteFaultIn;
      jabLatch  <= jabberIn;
    end else begin
      linkLatch <= linkLatch & linkUp;
      rfLatch   <= rfLatch | remoteFaultIn;
      jabLatch  <= jabLatch | jabberIn;
    end
  end

  assign cntClr   = anCompleteIn || strb.anEnRise;
  assign faultSet = msRoleConflict || (msFailPulse && failCnt == LAST_V);
  assign faultClr = strb.rdMsStat || cntClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failCnt  <= '0;
      cfgFault <= 1'b0;
    end else begin
      if (cntClr)
        failCnt <= '0;
      else if (msFailPulse && failCnt != LIMIT_V)
        failCnt <= failCnt + 1'b1;
      if (faultSet)
        cfgFault <= 1'b1;
      else if (faultClr)
        cfgFault <= 1'b0;
    end
  end

  sat_clr_counter #(.W(RXERR_W)) u_rxErr (
    .clk(clk), .rstN(rstN), .clr(strb.rdRxErr), .inc(rxErrPulse), .cnt(rxErrCnt)
  );

  sat_clr_counter #(.W(IDLE_W)) u_idleErr (
    .clk(clk), .rstN(rstN), .clr(strb.rdMsStat), .inc(idleErrPulse), .cnt(idleErrCnt)
  );
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int RXERR_W    = 16,
  parameter int IDLE_W     = 8,
  parameter int FAIL_LIMIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              linkUp,
  input  logic              remoteFaultIn,
  input  logic              jabberIn,
  input  logic              anCompleteIn,
  input  logic              rxErrPulse,
  input  logic              idleErrPulse,
  input  logic              msFailPulse,
  input  logic              msRoleConflict,
  output logic              swResetPulse,
  output logic              restartAnPulse
);
  strobes_t strb;
  logic [DATA_W-1:0] ctrlWord, msCtlWord;
  logic linkLatch, rfLatch, jabLatch, cfgFault;
  logic [RXERR_W-1:0] rxErrCnt;
  logic [IDLE_W-1:0]  idleErrCnt;

  phy_mgmt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .ctrlWord(ctrlWord), .msCtlWord(msCtlWord), .strb(strb),
    .swResetPulse(swResetPulse), .restartAnPulse(restartAnPulse)
  );

  phy_mgmt_stat #(.RXERR_W(RXERR_W), .IDLE_W(IDLE_W), .FAIL_LIMIT(FAIL_LIMIT)) u_stat (
    .clk(clk), .rstN(rstN), .strb(strb), .linkUp(linkUp),
    .remoteFaultIn(remoteFaultIn), .jabberIn(jabberIn), .anCompleteIn(anCompleteIn),
    .rxErrPulse(rxErrPulse), .idleErrPulse(idleErrPulse), .msFailPulse(msFailPulse),
    .msRoleConflict(msRoleConflict), .linkLatch(linkLatch), .rfLatch(rfLatch),
    .jabLatch(jabLatch), .cfgFault(cfgFault), .rxErrCnt(rxErrCnt), .idleErrCnt(idleErrCnt)
  );

  always_comb begin
    case (regAddr)
      ADDR_CTRL:   rdData = ctrlWord;
      ADDR_STATUS: rdData = {7'b0, 1'b1, 1'b0, 1'b1, anCompleteIn, rfLatch,
                             1'b1, linkLatch, jabLatch, 1'b1};
      ADDR_MSCTL:  rdData = msCtlWord;
      ADDR_MSSTAT: rdData = {cfgFault, {(DATA_W-1-IDLE_W){1'b0}}, idleErrCnt};
      ADDR_RXERR:  rdData = DATA_W'(rxErrCnt);
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/phy_mgmt_regs_chk.sv
module phy_mgmt_regs_chk
  import phy_mgmt_pkg::*;
#(
  parameter int RXERR_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [REG_AW-1:0]  regAddr,
  input logic               rdEn,
  input logic [DATA_W-1:0]  rdData,
  input logic               linkUp,
  input logic               remoteFaultIn,
  input logic               msRoleConflict,
  input logic               swResetPulse,
  input logic               restartAnPulse,
  input logic               linkLatch,
  input logic               rfLatch,
  input logic               cfgFault,
  input logic [RXERR_W-1:0] rxErrCnt
);
  AST_SWRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    swResetPulse |=> !swResetPulse); // R2
  AST_RESTART_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    restartAnPulse |=> !restartAnPulse); // R2
  AST_LINK_DROP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !linkUp |=> !linkLatch); // R4
  AST_REMOTE_FAULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    remoteFaultIn |=> rfLatch); // R5
  AST_RXERR_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (rxErrCnt == '1 && !(rdEn && regAddr == ADDR_RXERR)) |=> rxErrCnt == '1); // R7
  AST_CONFLICT_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    msRoleConflict |=> cfgFault); // R9
  AST_STATUS_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_STATUS) |-> (rdData[8] && rdData[6] && rdData[3] && rdData[0])); // R11
endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk #(.RXERR_W(RXERR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .rdEn(rdEn), .rdData(rdData),
  .linkUp(linkUp), .remoteFaultIn(remoteFaultIn), .msRoleConflict(msRoleConflict),
  .swResetPulse(swResetPulse), .restartAnPulse(restartAnPulse),
  .linkLatch(linkLatch), .rfLatch(rfLatch), .cfgFault(cfgFault), .rxErrCnt(rxErrCnt)
);

// File: tb/phy_mgmt_regs_bench.sv
`timescale 1ns/1ps
module phy_mgmt_regs_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] regAddr = '0;
  logic wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic rdEn = 1'b0;
  logic [15:0] rdData;
  logic linkUp = 1'b0, remoteFaultIn = 1'b0, jabberIn = 1'b0, anCompleteIn = 1'b0;
  logic rxErrPulse = 1'b0, idleErrPulse = 1'b0, msFailPulse = 1'b0, msRoleConflict = 1'b0;
  logic swResetPulse, restartAnPulse;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  phy_mgmt_regs u_phy_mgmt_regs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .linkUp(linkUp), .remoteFaultIn(remoteFaultIn),
    .jabberIn(jabberIn), .anCompleteIn(anCompleteIn), .rxErrPulse(rxErrPulse),
    .idleErrPulse(idleErrPulse), .msFailPulse(msFailPulse),
    .msRoleConflict(msRoleConflict), .swResetPulse(swResetPulse),
    .restartAnPulse(restartAnPulse)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic readReg(input logic [4:0] a, output logic [15:0] v);
    @(negedge clk);
    regAddr = a; rdEn = 1'b1;
    #1 v = rdData;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic writeReg(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    logic [15:0] v;
    readReg(5'd0, v);  check("R1 ctrl", v, 16'h1140);
    readReg(5'd1, v);  check("R1 status", v, 16'h0149);
    readReg(5'd9, v);  check("R1 msctl", v, 16'h0E00);
    readReg(5'd10, v); check("R1 msstat", v, 16'h0000);
    readReg(5'd21, v); check("R1 rxerr", v, 16'h0000);
  endtask

  task automatic testSelfClear();
    logic [15:0] v;
    writeReg(5'd0, 16'h1340);
    check("R2 restart pulse high", {15'b0, restartAnPulse}, 16'h1);
    check("R2 restart bit reads 1", rdData, 16'h1340);
    cycles(1);
    check("R2 restart pulse low", {15'b0, restartAnPulse}, 16'h0);
    readReg(5'd0, v); check("R2 restart bit cleared", v, 16'h1140);
  endtask

  task automatic testSoftReset();
    logic [15:0] v;
    writeReg(5'd9, 16'hF100);
    readReg(5'd9, v); check("R3 msctl written", v, 16'hF100);
    writeReg(5'd0, 16'h4800);
    readReg(5'd0, v); check("R3 ctrl written", v, 16'h4800);
    writeReg(5'd0, 16'h8000);
    check("R2 swreset pulse high", {15'b0, swResetPulse}, 16'h1);
    cycles(1);
    check("R2 swreset pulse low", {15'b0, swResetPulse}, 16'h0);
    readReg(5'd0, v); check("R3 ctrl restored", v, 16'h1140);
    readReg(5'd9, v); check("R3 msctl retained", v, 16'h1100);
  endtask

  task automatic testLinkLatch();
    logic [15:0] v;
    @(negedge clk) linkUp = 1'b1;
    readReg(5'd1, v); check("R4 link first read low", {15'b0, v[2]}, 16'h0);
    readReg(5'd1, v); check("R4 link reloaded high", {15'b0, v[2]}, 16'h1);
    @(negedge clk) linkUp = 1'b0;
    @(negedge clk) linkUp = 1'b1;
    cycles(2);
    readReg(5'd1, v); check("R4 link drop held", {15'b0, v[2]}, 16'h0);
    readReg(5'd1, v); check("R4 link after read", {15'b0, v[2]}, 16'h1);
  endtask

  task automatic testLatchHigh();
    logic [15:0] v;
    @(negedge clk) remoteFaultIn = 1'b1;
    @(negedge clk) remoteFaultIn = 1'b0; jabberIn = 1'b1;
    @(negedge clk) jabberIn = 1'b0;
    cycles(2);
    readReg(5'd1, v); check("R5 fault and jabber held", v & 16'h0012, 16'h0012);
    readReg(5'd1, v); check("R5 cleared after read", v & 16'h0012, 16'h0000);
  endtask

  task automatic testCoincide();
    logic [15:0] v;
    @(negedge clk);
    regAddr = 5'd1; rdEn = 1'b1; jabberIn = 1'b1; linkUp = 1'b0;
    #1 v = rdData;
    check("R6 read before event", v & 16'h0006, 16'h0004);
    @(posedge clk); #1;
    rdEn = 1'b0; jabberIn = 1'b0; linkUp = 1'b1;
    readReg(5'd1, v); check("R6 event kept", v & 16'h0006, 16'h0002);
    readReg(5'd1, v); check("R6 clean after", v & 16'h0006, 16'h0004);
    @(negedge clk);
    regAddr = 5'd21; rdEn = 1'b1; rxErrPulse = 1'b1;
    @(posedge clk); #1;
    rdEn = 1'b0; rxErrPulse = 1'b0;
    readReg(5'd21, v); check("R6 count kept", v, 16'h0001);
  endtask

  task automatic testRxErr();
    logic [15:0] v;
    @(negedge clk) rxErrPulse = 1'b1;
    repeat (5) @(negedge clk);
    rxErrPulse = 1'b0;
    readReg(5'd21, v); check("R7 count five", v, 16'h0005);
    readReg(5'd21, v); check("R7 cleared", v, 16'h0000);
    @(negedge clk) rxErrPulse = 1'b1;
    repeat (65540) @(negedge clk);
    rxErrPulse = 1'b0;
    readReg(5'd21, v); check("R7 saturated", v, 16'hFFFF);
    readReg(5'd21, v); check("R7 cleared after sat", v, 16'h0000);
  endtask

  task automatic testIdleErr();
    logic [15:0] v;
    @(negedge clk) idleErrPulse = 1'b1;
    repeat (300) @(negedge clk);
    idleErrPulse = 1'b0;
    readReg(5'd10, v); check("R8 idle saturated", v, 16'h00FF);
    readReg(5'd10, v); check("R8 idle cleared", v, 16'h0000);
  endtask

  task automatic pulseFail(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) msFailPulse = 1'b1;
      @(negedge clk) msFailPulse = 1'b0;
    end
  endtask

  task automatic pulseComplete();
    @(negedge clk) anCompleteIn = 1'b1;
    @(negedge clk) anCompleteIn = 1'b0;
  endtask

  task automatic testFault();
    logic [15:0] v;
    pulseComplete();
    pulseFail(6);
    readReg(5'd10, v); check("R9 six fails no fault", v, 16'h0000);
    pulseFail(1);
    readReg(5'd10, v); check("R9 seventh fail sets", v, 16'h8000);
    readReg(5'd10, v); check("R10 read clears", v, 16'h0000);
    pulseComplete();
    pulseFail(6);
    readReg(5'd10, v); check("R10 count restarted", v, 16'h0000);
    pulseComplete();
    @(negedge clk) msRoleConflict = 1'b1;
    @(negedge clk) msRoleConflict = 1'b0;
    check("R9 conflict sets", rdData, 16'h8000);
    pulseComplete();
    #1 check("R10 complete clears", rdData, 16'h0000);
    @(negedge clk) msRoleConflict = 1'b1;
    @(negedge clk) msRoleConflict = 1'b0;
    writeReg(5'd0, 16'h0140);
    writeReg(5'd0, 16'h1140);
    cycles(2);
    readReg(5'd10, v); check("R10 enable rise clears", v, 16'h0000);
    @(negedge clk) anCompleteIn = 1'b1;
    readReg(5'd1, v); check("R11 complete bit", v & 16'h0169, 16'h0169);
    @(negedge clk) anCompleteIn = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    cycles(3);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testSelfClear();
    testSoftReset();
    testLinkLatch();
    testLatchHigh();
    testCoincide();
    testRxErr();
    testIdleErr();
    testFault();
    finishRun();
  end
endmodule